// File: doc/BRIEF.md
# Single-Shot Pulse Width Capture

This block measures the width of one high pulse on an external capture pin. A free-running 8-bit up-counter serves as the time base. Software arms a measurement through a start bit in a control byte. The block then stores the counter value at the first rising edge of the pin and the counter value at the following falling edge. After the falling-edge capture it clears the start bit by itself, so each arming yields exactly one measurement.

The pin passes through a two-flop synchronizer. Edges are found by comparing the synchronized level with its value one clock earlier. A separate enable byte decides whether edges from the pin reach the capture logic. A small register interface gives software access to the enable byte and the control byte, and read access to both capture registers. The start bit is protected: a write of 1 sets it only when the preceding access to the control byte was a read that returned 0. The pulse width in counter ticks is the fall capture minus the rise capture, modulo 256.

Top module: `pwc_capture_top`

## Requirements
- R1: The 8-bit counter is 0 during reset and increments by one on every clock edge after reset, wrapping from 255 to 0. An edge on the pin that settles at bench drive time t is captured as the counter value two clocks later.
- R2: While the start bit (control byte at address 1, bit 0) is 0, neither capture register changes.
- R3: Once armed, the first rising edge seen on the enabled pin loads the counter value into the rise register (address 2).
- R4: After that rising edge, the next falling edge loads the counter value into the fall register (address 3).
- R5: The falling-edge capture clears the start bit to 0 in the same update, and no further captures follow.
- R6: A write of 1 to the start bit takes effect only if the previous access to the control byte was a read that returned start = 0. Every write to the control byte uses up that permission.
- R7: The enable byte (address 0, bit 0) gates the pin. While it is 0, pin edges cause no capture and the block stays armed.
- R8: Reserved bits 7:1 of the enable byte read as 1 and reserved bits 7:1 of the control byte read as 0. Writes to reserved bits have no effect.
- R9: The rise and fall registers are read-only. Writes to addresses 2 and 3 leave them unchanged.
- R10: A falling edge seen while armed but before any rising edge is ignored, and the block keeps waiting for a rise.
- R11: A write of 0 to the start bit during a measurement aborts it and returns the block to idle. A capture register that was already loaded keeps its value.
- R12: After reset the start bit is 0, the pin enable is 0, both capture registers read 0, and the block is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_pin | input | 1 | Asynchronous external capture pin |
| bus_addr | input | 2 | Register address: 0 enable, 1 control, 2 rise, 3 fall |
| bus_wr | input | 1 | Write strobe, one access per asserted clock |
| bus_rd | input | 1 | Read strobe, needed to qualify a later start write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |

## Verification
The main function is exercised with a sweep of pulse widths from 1 to 60 clocks and with widths of 255, 256 and 300 clocks. The wider pulses show that the fall-minus-rise difference wraps modulo 256 and that the captured values follow the counter across its wrap, not a reset of it. Further patterns separate the rules around the measurement: a pin already high when the block is armed, so that its fall must be ignored; edges arriving while the pin is disabled; an abort between the two captures; a start write not preceded by a read; and writes to the reserved bits and to the read-only registers.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
    localparam int CNT_W  = 8;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADR_ENABLE = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_CTRL   = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_RISE   = 2'd2;
    localparam logic [ADDR_W-1:0] ADR_FALL   = 2'd3;

    typedef enum logic [1:0] {
        PH_IDLE      = 2'd0,
        PH_WAIT_RISE = 2'd1,
        PH_WAIT_FALL = 2'd2
    } phase_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_ev_t;

    typedef struct packed {
        logic                  wr;
        logic                  rd;
        logic [ADDR_W-1:0]     addr;
        logic [DATA_W-1:0]     data;
    } bus_req_t;

    function automatic logic [DATA_W-1:0] enable_view(input logic en);
        return {{(DATA_W-1){1'b1}}, en};
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_view(input logic armed);
        return {{(DATA_W-1){1'b0}}, armed};
    endfunction
endpackage

// File: rtl/pwc_counter.sv
module pwc_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= count + 1'b1;
    end

    assert_count_step_R1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> count == $past(count) + 1'b1);
endmodule

// File: rtl/pwc_edge_sync.sv
module pwc_edge_sync
    import pwc_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     pin,
    input  logic     enable,
    output edge_ev_t ev
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= pin;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= 1'b0;
            else     chain[s] <= chain[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= chain[STAGES-1];
    end

    always_comb begin
        ev.rise = enable &  chain[STAGES-1] & ~prev;
        ev.fall = enable & ~chain[STAGES-1] &  prev;
    end

    assert_single_edge_R7: assert property (@(posedge clk) disable iff (rst)
        !(ev.rise && ev.fall));
endmodule

// File: rtl/pwc_capture_ctrl.sv
module pwc_capture_ctrl
    import pwc_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  edge_ev_t     ev,
    input  logic [W-1:0] count,
    input  logic         ctrl_rd,
    input  logic         ctrl_wr,
    input  logic         start_val,
    output logic         armed,
    output logic [W-1:0] rise_q,
    output logic [W-1:0] fall_q
);
    phase_t phase;
    logic   read_ok;
    logic   sw_abort;
    logic   sw_arm;

    assign sw_abort = ctrl_wr && !start_val;
    assign sw_arm   = ctrl_wr && start_val && read_ok && (phase == PH_IDLE);
    assign armed    = (phase != PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst)          read_ok <= 1'b0;
        else if (ctrl_wr) read_ok <= 1'b0;
        else if (ctrl_rd) read_ok <= (phase == PH_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            rise_q <= '0;
            fall_q <= '0;
        end else if (sw_abort) begin
            phase <= PH_IDLE;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (sw_arm) phase <= PH_WAIT_RISE;
                end
                PH_WAIT_RISE: begin
                    if (ev.rise) begin
                        rise_q <= count;
                        phase  <= PH_WAIT_FALL;
                    end
                end
                PH_WAIT_FALL: begin
                    if (ev.fall) begin
                        fall_q <= count;
                        phase  <= PH_IDLE;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assert_idle_holds_regs_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |=> ($stable(rise_q) && $stable(fall_q)));

    assert_rise_loads_count_R3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WAIT_RISE && ev.rise && !sw_abort) |=> rise_q == $past(count));

    assert_fall_disarms_R5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WAIT_FALL && ev.fall) |=> !armed);

    assert_arm_needs_read_R6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && !read_ok) |=> !armed);

    assert_early_fall_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WAIT_RISE && !ev.rise && !sw_abort) |=> phase == PH_WAIT_RISE);

    assert_abort_idle_R11: assert property (@(posedge clk) disable iff (rst)
        sw_abort |=> !armed);
endmodule

// File: rtl/pwc_capture_top.sv
module pwc_capture_top
    import pwc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_pin,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    bus_req_t         req;
    edge_ev_t         ev;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] rise_q;
    logic [CNT_W-1:0] fall_q;
    logic             pin_en;
    logic             armed;

    always_comb begin
        req.wr   = bus_wr;
        req.rd   = bus_rd;
        req.addr = bus_addr;
        req.data = bus_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)                                pin_en <= 1'b0;
        else if (req.wr && req.addr == ADR_ENABLE) pin_en <= req.data[0];
    end

    pwc_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .count (count)
    );

    pwc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin    (cap_pin),
        .enable (pin_en),
        .ev     (ev)
    );

    pwc_capture_ctrl #(.W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .count     (count),
        .ctrl_rd   (req.rd && req.addr == ADR_CTRL),
        .ctrl_wr   (req.wr && req.addr == ADR_CTRL),
        .start_val (req.data[0]),
        .armed     (armed),
        .rise_q    (rise_q),
        .fall_q    (fall_q)
    );

    always_comb begin
        unique case (req.addr)
            ADR_ENABLE: bus_rdata = enable_view(pin_en);
            ADR_CTRL:   bus_rdata = ctrl_view(armed);
            ADR_RISE:   bus_rdata = rise_q;
            default:    bus_rdata = fall_q;
        endcase
    end

    assert_reserved_ctrl_R8: assert property (@(posedge clk) disable iff (rst)
        (req.addr == ADR_CTRL) |-> bus_rdata[DATA_W-1:1] == '0);

    assert_readonly_caps_R9: assert property (@(posedge clk) disable iff (rst)
        (req.wr && (req.addr == ADR_RISE || req.addr == ADR_FALL) && !armed)
            |=> ($stable(rise_q) && $stable(fall_q)));
endmodule

// File: tb/sim_pwc_capture_top.sv
module sim_pwc_capture_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cap_pin = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    logic [7:0] tc;

    always #2.5 clk = ~clk;

    pwc_capture_top u0 (
        .clk(clk), .rst(rst), .cap_pin(cap_pin), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // independent time base model for R1
    always @(posedge clk) begin
        if (rst) tc <= 8'd0;
        else     tc <= tc + 8'd1;
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            failures = failures + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1; bus_rd = 1'b0;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic arm();
        logic [7:0] d;
        bus_read(2'd1, d);
        bus_write(2'd1, 8'h01);
    endtask

    task automatic set_pin(input logic v, output logic [7:0] exp);
        @(negedge clk);
        cap_pin = v;
        exp = tc + 8'd2;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [7:0] d, er, ef, er2, junk;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle(2);

        // R12 / R8 reset view
        bus_read(2'd0, d); check("R12 enable reset", d, 8'hFE);
        bus_read(2'd2, d); check("R12 rise reset", d, 8'h00);
        bus_read(2'd3, d); check("R12 fall reset", d, 8'h00);
        bus_read(2'd1, d); check("R12 ctrl reset", d, 8'h00);

        // R6: write 1 without a fresh read of 0
        bus_write(2'd1, 8'h00);
        bus_write(2'd1, 8'h01);
        bus_read(2'd1, d); check("R6 set without read", d, 8'h00);

        // R8 reserved bits
        bus_write(2'd0, 8'hFE);
        bus_read(2'd0, d); check("R8 enable reserved write", d, 8'hFE);
        bus_read(2'd1, d);
        bus_write(2'd1, 8'hFE);
        bus_read(2'd1, d); check("R8 ctrl reserved write", d, 8'h00);

        // R7/R2: pin disabled, armed, pulse must not capture
        arm();
        bus_read(2'd1, d); check("R6 set after read", d, 8'h01);
        set_pin(1'b1, junk); idle(5);
        set_pin(1'b0, junk); idle(5);
        bus_read(2'd1, d); check("R7 still armed", d, 8'h01);
        bus_read(2'd2, d); check("R7 rise untouched", d, 8'h00);
        bus_read(2'd3, d); check("R7 fall untouched", d, 8'h00);
        bus_write(2'd1, 8'h00);
        bus_write(2'd0, 8'h01);
        bus_read(2'd0, d); check("R7 enable on", d, 8'hFF);

        // R2: idle pulse with pin enabled
        set_pin(1'b1, junk); idle(4);
        set_pin(1'b0, junk); idle(4);
        bus_read(2'd2, d); check("R2 idle rise", d, 8'h00);
        bus_read(2'd3, d); check("R2 idle fall", d, 8'h00);

        // R10: pin high at arm time, its fall ignored
        set_pin(1'b1, junk); idle(4);
        arm();
        set_pin(1'b0, junk); idle(4);
        bus_read(2'd1, d); check("R10 still armed after early fall", d, 8'h01);
        bus_read(2'd3, d); check("R10 fall untouched", d, 8'h00);
        set_pin(1'b1, er); idle(6);
        set_pin(1'b0, ef); idle(5);
        bus_read(2'd1, d); check("R5 self clear", d, 8'h00);
        bus_read(2'd2, d); check("R3 rise after early fall", d, er);
        bus_read(2'd3, d); check("R4 fall after early fall", d, ef);

        // R9: capture registers read-only
        bus_write(2'd2, 8'h5A);
        bus_write(2'd3, 8'hA5);
        bus_read(2'd2, d); check("R9 rise read-only", d, er);
        bus_read(2'd3, d); check("R9 fall read-only", d, ef);

        // R11: abort between captures
        arm();
        set_pin(1'b1, er2); idle(5);
        bus_write(2'd1, 8'h00);
        set_pin(1'b0, junk); idle(5);
        bus_read(2'd1, d); check("R11 aborted idle", d, 8'h00);
        bus_read(2'd2, d); check("R11 rise kept", d, er2);
        bus_read(2'd3, d); check("R11 fall unchanged", d, ef);

        // R3/R4/R5/R1 sweep over widths, including counter wrap
        for (int w = 1; w <= 63; w++) begin
            int width;
            width = (w <= 60) ? w : ((w == 61) ? 255 : ((w == 62) ? 256 : 300));
            arm();
            set_pin(1'b1, er);
            idle(width - 1);
            set_pin(1'b0, ef);
            idle(4);
            check("R1 width mod 256", ef - er, width[7:0]);
            bus_read(2'd1, d); check("R5 sweep self clear", d, 8'h00);
            bus_read(2'd2, d); check("R3 sweep rise", d, er);
            bus_read(2'd3, d); check("R4 sweep fall", d, ef);
            // R5: a second pulse after completion is not captured
            set_pin(1'b1, junk); idle(3);
            set_pin(1'b0, junk); idle(3);
            bus_read(2'd2, d); check("R5 no recapture", d, er);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule